// File: doc/BRIEF.md
# Sequential FIR Filter Datapath

This block is the arithmetic half of a 16-tap FIR filter that computes each output sample with a single multiplier-accumulator over many clock cycles. It holds the recent input history and a tap read address. It also holds a fixed coefficient table, a wide accumulator and a scaled output register. It makes no sequencing decisions of its own. An external controller drives it with one-cycle strobes.

The controller runs a typical sample in four phases. In the first cycle it raises the load, address-init and sum-clear strobes together. It then raises increment-address and accumulate on every cycle until the datapath reports that the final tap is being processed. It raises load-output for one cycle after that, and then goes idle. The done flag is combinational, so the last product is added in the same cycle in which the controller sees done high. The stored result is the accumulator shifted right arithmetically by 7 and clamped to the signed 8-bit range.

Top module: `fir_seq_datapath`

## Requirements
- R1: While reset is high, and directly after it falls, the output register reads 0, the tap address is 0 (so done is low) and the accumulator is cleared.
- R2: When load_shift is high at a clock edge, x_in becomes history entry 0 and every entry k takes the old value of entry k-1. The oldest entry is discarded. With load_shift low the history holds.
- R3: init_addr sets the tap address to 0 at the clock edge. It takes priority over incr_addr.
- R4: init_sum clears the accumulator at the clock edge. It takes priority over load_sum.
- R5: A load_sum edge adds history[addr] × coef[addr] to the accumulator, as a signed 20-bit value. An incr_addr edge advances the address by one, wrapping from 15 to 0.
- R6: done is high exactly when the tap address equals 15. It follows the address with no register delay.
- R7: A load_out edge stores the accumulator, arithmetically shifted right by 7, into y_out.
- R8: When that shifted value is above 127 it is stored as 127, and when it is below -128 it is stored as -128.
- R9: With load_out low, y_out keeps its value.
- R10: Reset is asynchronous and active high. Raising it between clock edges clears y_out and done at once.
- R11: Coefficient k (0..15) is ((23·k + 5) mod 200) − 100, an 8-bit signed constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| x_in | input | 8 | Signed input sample |
| load_shift | input | 1 | Push x_in into the history |
| init_addr | input | 1 | Set tap address to 0 |
| incr_addr | input | 1 | Advance tap address |
| init_sum | input | 1 | Clear accumulator |
| load_sum | input | 1 | Accumulate current tap product |
| load_out | input | 1 | Capture scaled, saturated result |
| y_out | output | 8 | Signed filtered sample |
| done | output | 1 | Address is at the last tap |

## Verification
The hardest states to reach from the ports are saturation at both ends. Saturation needs every history entry to carry a full-scale value whose sign matches the overall sum of the coefficients. The bench therefore pushes sixteen consecutive +127 samples and then sixteen −128 samples, so the accumulated sums lie far outside the 8-bit range in each direction. An asynchronous reset is also dropped into the middle of an accumulation loop. A strobe cycle with conflicting strobes checks the init-over-accumulate priority.

// File: rtl/fir_seq_pkg.sv
package fir_seq_pkg;
    localparam int TAPS     = 16;
    localparam int SAMPLE_W = 8;
    localparam int COEF_W   = 8;
    localparam int ACC_W    = 20;
    localparam int SCALE_SH = 7;
    localparam int ADDR_W   = $clog2(TAPS);

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [ACC_W-1:0]    acc_t;
    typedef logic [ADDR_W-1:0]          addr_t;

    typedef struct packed {
        logic load_shift;
        logic init_addr;
        logic incr_addr;
        logic init_sum;
        logic load_sum;
        logic load_out;
    } strobe_t;

    // Coefficient k of the fixed table.
    function automatic coef_t coef_at(input int k);
        int v;
        v = ((23 * k + 5) % 200) - 100;
        return coef_t'(v);
    endfunction
endpackage

// File: rtl/fir_sample_line.sv
module fir_sample_line #(
    parameter int TAPS     = fir_seq_pkg::TAPS,
    parameter int SAMPLE_W = fir_seq_pkg::SAMPLE_W,
    localparam int ADDR_W  = $clog2(TAPS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic signed [SAMPLE_W-1:0] din,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic signed [SAMPLE_W-1:0] rd_data
);
    logic signed [SAMPLE_W-1:0] hist [TAPS];

    always_ff @(posedge clk or posedge rst) begin
        if (rst)       hist[0] <= '0;
        else if (push) hist[0] <= din;
    end

    for (genvar g = 1; g < TAPS; g++) begin : g_stage
        always_ff @(posedge clk or posedge rst) begin
            if (rst)       hist[g] <= '0;
            else if (push) hist[g] <= hist[g-1];
        end
    end

    assign rd_data = hist[rd_addr];

    // R2: entry 1 takes the previous head after a push
    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        push |=> hist[1] == $past(hist[0]));
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !push |=> $stable(hist[0]));
endmodule

// File: rtl/fir_tap_counter.sv
module fir_tap_counter #(
    parameter int TAPS    = fir_seq_pkg::TAPS,
    localparam int ADDR_W = $clog2(TAPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              incr,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(TAPS - 1);

    always_ff @(posedge clk or posedge rst) begin
        if (rst)       addr <= '0;
        else if (init) addr <= '0;
        else if (incr) addr <= (addr == LAST_IDX) ? '0 : addr + 1'b1;
    end

    assign last = (addr == LAST_IDX);

    // R3: init wins and zeroes the address
    p_init_r3: assert property (@(posedge clk) disable iff (rst)
        init |=> addr == '0);
    // R5: the address moves by one per increment
    p_incr_r5: assert property (@(posedge clk) disable iff (rst)
        (incr && !init && addr != LAST_IDX) |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
    parameter int TAPS     = fir_seq_pkg::TAPS,
    parameter int SAMPLE_W = fir_seq_pkg::SAMPLE_W,
    parameter int COEF_W   = fir_seq_pkg::COEF_W,
    parameter int ACC_W    = fir_seq_pkg::ACC_W,
    localparam int ADDR_W  = $clog2(TAPS),
    localparam int PROD_W  = SAMPLE_W + COEF_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       accum,
    input  logic [ADDR_W-1:0]          addr,
    input  logic signed [SAMPLE_W-1:0] tap_sample,
    output logic signed [ACC_W-1:0]    acc
);
    logic signed [COEF_W-1:0] coef_tbl [TAPS];
    logic signed [COEF_W-1:0] coef_sel;
    logic signed [PROD_W-1:0] product;

    for (genvar g = 0; g < TAPS; g++) begin : g_coef
        assign coef_tbl[g] = COEF_W'(fir_seq_pkg::coef_at(g));
    end

    assign coef_sel = coef_tbl[addr];
    assign product  = tap_sample * coef_sel;

    always_ff @(posedge clk or posedge rst) begin
        if (rst)        acc <= '0;
        else if (clear) acc <= '0;
        else if (accum) acc <= acc + ACC_W'(product);
    end

    // R4: clear wins over accumulate
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        clear |=> acc == '0);
    p_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!clear && !accum) |=> $stable(acc));
endmodule

// File: rtl/fir_out_stage.sv
module fir_out_stage #(
    parameter int ACC_W    = fir_seq_pkg::ACC_W,
    parameter int SAMPLE_W = fir_seq_pkg::SAMPLE_W,
    parameter int SCALE_SH = fir_seq_pkg::SCALE_SH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic signed [ACC_W-1:0]    acc,
    output logic signed [SAMPLE_W-1:0] y
);
    localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MIN_V = -ACC_W'(1 << (SAMPLE_W - 1));

    logic signed [ACC_W-1:0]    scaled;
    logic signed [SAMPLE_W-1:0] clamped;

    assign scaled = acc >>> SCALE_SH;

    always_comb begin
        if (scaled > MAX_V)      clamped = MAX_V[SAMPLE_W-1:0];
        else if (scaled < MIN_V) clamped = MIN_V[SAMPLE_W-1:0];
        else                     clamped = scaled[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst)       y <= '0;
        else if (load) y <= clamped;
    end

    // R9: no load, no change
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(y));
endmodule

// File: rtl/fir_seq_datapath.sv
module fir_seq_datapath
    import fir_seq_pkg::*;
#(
    parameter int P_TAPS     = TAPS,
    parameter int P_SAMPLE_W = SAMPLE_W,
    parameter int P_COEF_W   = COEF_W,
    parameter int P_ACC_W    = ACC_W,
    parameter int P_SHIFT    = SCALE_SH,
    localparam int AW        = $clog2(P_TAPS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic signed [P_SAMPLE_W-1:0] x_in,
    input  logic                         load_shift,
    input  logic                         init_addr,
    input  logic                         incr_addr,
    input  logic                         init_sum,
    input  logic                         load_sum,
    input  logic                         load_out,
    output logic signed [P_SAMPLE_W-1:0] y_out,
    output logic                         done
);
    strobe_t                       stb;
    logic [AW-1:0]                 addr;
    logic signed [P_SAMPLE_W-1:0]  tap_sample;
    logic signed [P_ACC_W-1:0]     acc;

    assign stb = '{load_shift: load_shift, init_addr: init_addr,
                   incr_addr: incr_addr, init_sum: init_sum,
                   load_sum: load_sum, load_out: load_out};

    fir_sample_line #(.TAPS(P_TAPS), .SAMPLE_W(P_SAMPLE_W)) u_line (
        .clk(clk), .rst(rst), .push(stb.load_shift), .din(x_in),
        .rd_addr(addr), .rd_data(tap_sample));

    fir_tap_counter #(.TAPS(P_TAPS)) u_cnt (
        .clk(clk), .rst(rst), .init(stb.init_addr), .incr(stb.incr_addr),
        .addr(addr), .last(done));

    fir_mac #(.TAPS(P_TAPS), .SAMPLE_W(P_SAMPLE_W), .COEF_W(P_COEF_W),
              .ACC_W(P_ACC_W)) u_mac (
        .clk(clk), .rst(rst), .clear(stb.init_sum), .accum(stb.load_sum),
        .addr(addr), .tap_sample(tap_sample), .acc(acc));

    fir_out_stage #(.ACC_W(P_ACC_W), .SAMPLE_W(P_SAMPLE_W),
                    .SCALE_SH(P_SHIFT)) u_out (
        .clk(clk), .rst(rst), .load(stb.load_out), .acc(acc), .y(y_out));

    // R6: done drops after a wrap or init
    p_done_r6: assert property (@(posedge clk) disable iff (rst)
        (done && (init_addr || incr_addr)) |=> !done);
endmodule

// File: tb/sim_fir_seq_datapath.sv
`timescale 1ns/1ps
module sim_fir_seq_datapath;
    logic clk = 0, rst = 1;
    logic signed [7:0] x_in = 0;
    logic ls = 0, ia = 0, inc = 0, is = 0, lsum = 0, lo = 0;
    logic signed [7:0] y_out;
    logic done;

    int checks = 0, errors = 0;
    int hist [16];
    int maddr = 0, macc = 0, my = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fir_seq_datapath u0 (.clk(clk), .rst(rst), .x_in(x_in), .load_shift(ls),
        .init_addr(ia), .incr_addr(inc), .init_sum(is), .load_sum(lsum),
        .load_out(lo), .y_out(y_out), .done(done));

    function automatic int cf(int k);
        return ((23 * k + 5) % 200) - 100;
    endfunction

    function automatic int sat(int a);
        int s = a >>> 7;
        if (s > 127) return 127;
        if (s < -128) return -128;
        return s;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 16; k++) hist[k] = 0;
        maddr = 0; macc = 0; my = 0;
    endtask

    // One clock with given strobes; the model updates with the old state.
    task automatic cyc(bit a_ls, bit a_ia, bit a_inc, bit a_is, bit a_lsum,
                       bit a_lo, int xv);
        int oacc;
        x_in = 8'(xv); ls = a_ls; ia = a_ia; inc = a_inc; is = a_is;
        lsum = a_lsum; lo = a_lo;
        @(posedge clk);
        oacc = macc;
        if (a_lo) my = sat(oacc);                       // R7 R8
        if (a_is) macc = 0;                             // R4
        else if (a_lsum) macc = oacc + hist[maddr] * cf(maddr); // R5 R11
        if (a_ia) maddr = 0;                            // R3
        else if (a_inc) maddr = (maddr + 1) % 16;
        if (a_ls) begin                                 // R2
            for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = xv;
        end
        @(negedge clk);
        chk("R7/R9 y_out", y_out, my);
        chk("R6 done", done, maddr == 15);
        ls = 0; ia = 0; inc = 0; is = 0; lsum = 0; lo = 0;
    endtask

    // Plain convolution from the model history, independent of the loop.
    function automatic int conv();
        int s = 0;
        for (int k = 0; k < 16; k++) s += hist[k] * cf(k);
        return sat(s);
    endfunction

    task automatic run_sample(int xv);
        bit last;
        int exp_y;
        cyc(1, 1, 0, 1, 0, 0, xv);
        for (int n = 0; n < 40; n++) begin
            last = done;
            cyc(0, 0, 1, 0, 1, 0, 0);
            if (last) break;
        end
        exp_y = conv();
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R5/R8/R11 convolution", y_out, exp_y);
        cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        #12;
        chk("R1 reset y", y_out, 0);
        chk("R1 reset done", done, 0);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk("R1 after reset y", y_out, 0);

        // Impulse followed by zeros walks the impulse across the taps.
        run_sample(100);
        for (int i = 0; i < 16; i++) run_sample(0);
        // Full-scale steps for both saturation ends.
        for (int i = 0; i < 16; i++) run_sample(127);
        chk("R8 positive-step clamp", y_out, -128);
        for (int i = 0; i < 16; i++) run_sample(-128);
        chk("R8 negative-step clamp", y_out, 127);
        // A mixed pattern.
        for (int i = 0; i < 20; i++) run_sample(((i * 37) % 255) - 127);

        // R4: clear and accumulate together leaves zero.
        cyc(0, 1, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 1, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R4 clear priority", y_out, 0);
        // R3: init over increment mid-loop.
        cyc(0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 0, 0);
        chk("R3 init priority done", done, 0);
        // R6: reach address 15, then wrap.
        for (int i = 0; i < 15; i++) cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R6 done at 15", done, 1);
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk("R6 wrap", done, 0);

        // R10: asynchronous reset in the middle of a loop.
        run_sample(90);
        cyc(1, 1, 0, 1, 0, 0, 55);
        for (int i = 0; i < 15; i++) cyc(0, 0, 1, 0, 1, 0, 0);
        #1 rst = 1;
        #0.5;
        chk("R10 async y", y_out, 0);
        chk("R10 async done", done, 0);
        model_reset();
        @(negedge clk); rst = 0;
        run_sample(-77);
        run_sample(64);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule